// File: doc/BRIEF.md
# Fixed-Point Newton-Raphson Square Root

This block takes an unsigned 8-bit integer and returns its square root as a fixed-point number with 15 integer bits and 10 fractional bits. It also returns the same value as decimal digits: three BCD digits for the integer part and three BCD digits for the first three decimal places of the fraction. A one-cycle `start` pulse launches a computation. A one-cycle `done` pulse reports that the results are ready. The results then hold until the next computation completes.

The first estimate comes from a three-range table indexed by the input. Four Newton-Raphson updates follow, each of the form x' = (x + S/x) / 2. The quotient S/x comes from an internal restoring shift-subtract divider that produces one quotient bit per cycle. The controller forms the next estimate only after that divider has produced its last bit. An input of zero skips the iterations entirely.

Top module: `sqrt_nr`

## Requirements
- R1: After reset, `busy` and `done` are low and `root_fx`, `int_bcd` and `frac_bcd` are all zero.
- R2: The starting estimate is 5.0 for inputs below 32, 9.0 for inputs from 32 to 80, and 16.0 for inputs of 81 and above.
- R3: For an input S from 1 to 255, `root_fx` is bit-exact to the following procedure. The estimate X is an integer counting units of 2^-10, so bits [24:10] hold the integer part and bits [9:0] hold the fraction. X starts as seed*1024. Four times, the procedure sets Q = floor(S*2^20 / X) and then X = floor((X + Q) / 2).
- R4: A start with input 0 skips the iterations, drives all results to zero and raises `done` one cycle after the start cycle.
- R5: A start with a nonzero input raises `done` exactly 117 cycles after the start cycle. That is four updates of 29 cycles each (28 divider cycles plus one update cycle) plus one output cycle. `busy` is high from the cycle after the start until `done` rises.
- R6: `done` is high for exactly one cycle per computation, and `busy` is low in that cycle.
- R7: The results hold unchanged between `done` pulses, and a `start` pulse that arrives while `busy` is high has no effect.
- R8: `int_bcd` holds the integer part `root_fx[24:10]` as BCD: hundreds in [11:8], tens in [7:4] and units in [3:0].
- R9: `frac_bcd` holds floor(`root_fx[9:0]` * 1000 / 1024) as BCD, with the first decimal place in [11:8], the second in [7:4] and the third in [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| value | input | 8 | Unsigned operand, sampled with `start` |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| root_fx | output | 25 | Square root, 15 integer and 10 fraction bits |
| int_bcd | output | 12 | Integer part as three BCD digits |
| frac_bcd | output | 12 | First three decimal places as BCD digits |

## Verification
Some rules are checked by assertions on every cycle. These are: `done` is a one-cycle pulse that never overlaps `busy`, an accepted nonzero start raises `busy`, a zero start finishes at once with a zero result, the results hold between pulses, and every BCD digit is at most nine. The scenarios cover what only the sequence of results can show. They sweep every input from 0 to 255 and compare the fixed-point root and both digit groups with an arithmetic model, with the seed boundaries at 31/32 and 80/81 tagged separately. They also measure the exact latency and issue a start in mid-computation to show it is dropped.

// File: rtl/sqrt_nr.sv
module sqrt_nr #(
  parameter int ITERS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  value,
  output logic        busy,
  output logic        done,
  output logic [24:0] root_fx,
  output logic [11:0] int_bcd,
  output logic [11:0] frac_bcd
);
  localparam int FB = 10;
  localparam int IB = 15;
  localparam int W  = IB + FB;
  localparam int DW = 8 + 2 * FB;
  localparam int CW = $clog2(DW);
  localparam int IW = $clog2(ITERS + 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_UPD, S_FIN} st_t;

  st_t           st;
  logic [W-1:0]  est;
  logic [W-1:0]  rem;
  logic [DW-1:0] dvd;
  logic [DW-1:0] quo;
  logic [CW-1:0] bit_cnt;
  logic [IW-1:0] it_cnt;
  logic [7:0]    s_q;

  logic [W:0]      trial;
  logic            fits;
  logic [W:0]      avg_sum;
  logic [4:0]      seed;
  logic [2*FB-1:0] frac_prod;

  assign trial     = {rem, dvd[DW-1]};
  assign fits      = trial >= {1'b0, est};
  assign avg_sum   = {1'b0, est} + {1'b0, quo[W-1:0]};
  assign seed      = (value < 8'd32) ? 5'd5 : (value < 8'd81) ? 5'd9 : 5'd16;
  assign frac_prod = est[FB-1:0] * 10'd1000;
  assign busy      = (st != S_IDLE);

  function automatic logic [11:0] to_bcd3(input logic [9:0] bin);
    logic [11:0] acc;
    acc = '0;
    for (int i = 9; i >= 0; i--) begin
      if (acc[3:0]  >= 4'd5) acc[3:0]  = acc[3:0]  + 4'd3;
      if (acc[7:4]  >= 4'd5) acc[7:4]  = acc[7:4]  + 4'd3;
      if (acc[11:8] >= 4'd5) acc[11:8] = acc[11:8] + 4'd3;
      acc = {acc[10:0], bin[i]};
    end
    return acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      est      <= '0;
      rem      <= '0;
      dvd      <= '0;
      quo      <= '0;
      bit_cnt  <= '0;
      it_cnt   <= '0;
      s_q      <= '0;
      done     <= 1'b0;
      root_fx  <= '0;
      int_bcd  <= '0;
      frac_bcd <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (value == 8'd0) begin
            est <= '0;
            st  <= S_FIN;
          end else begin
            est     <= W'(seed) << FB;
            s_q     <= value;
            dvd     <= {value, {(2*FB){1'b0}}};
            rem     <= '0;
            bit_cnt <= '0;
            it_cnt  <= '0;
            st      <= S_DIV;
          end
        end
        S_DIV: begin
          rem     <= fits ? W'(trial - {1'b0, est}) : trial[W-1:0];
          quo     <= {quo[DW-2:0], fits};
          dvd     <= dvd << 1;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CW'(DW - 1)) st <= S_UPD;
        end
        S_UPD: begin
          est    <= avg_sum[W:1];
          it_cnt <= it_cnt + 1'b1;
          if (it_cnt == IW'(ITERS - 1)) begin
            st <= S_FIN;
          end else begin
            dvd     <= {s_q, {(2*FB){1'b0}}};
            rem     <= '0;
            bit_cnt <= '0;
            st      <= S_DIV;
          end
        end
        default: begin
          root_fx  <= est;
          int_bcd  <= to_bcd3(est[FB+9:FB]);
          frac_bcd <= to_bcd3(frac_prod[2*FB-1:FB]);
          done     <= 1'b1;
          st       <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module sqrt_nr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [7:0]  value,
  input logic        busy,
  input logic        done,
  input logic [24:0] root_fx,
  input logic [11:0] int_bcd,
  input logic [11:0] frac_bcd
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && value != 8'd0) |=> busy); // R5
  AST_ZERO_FAST: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && value == 8'd0) |=> ##1 (done && root_fx == 25'd0)); // R4
  AST_HOLD_ROOT: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(root_fx)); // R7
  AST_HOLD_BCD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(int_bcd) && $stable(frac_bcd))); // R7
  AST_FRAC_DIGITS: assert property (@(posedge clk) disable iff (!rst_n) (frac_bcd[3:0] <= 4'd9 && frac_bcd[7:4] <= 4'd9 && frac_bcd[11:8] <= 4'd9)); // R9
  AST_INT_DIGITS: assert property (@(posedge clk) disable iff (!rst_n) (int_bcd[3:0] <= 4'd9 && int_bcd[7:4] <= 4'd9 && int_bcd[11:8] <= 4'd9)); // R8
endmodule

bind sqrt_nr sqrt_nr_chk u_sqrt_nr_chk (.*);

// File: tb/test_sqrt_nr.sv
module test_sqrt_nr;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  value = 8'd0;
  logic        busy, done;
  logic [24:0] root_fx;
  logic [11:0] int_bcd, frac_bcd;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqrt_nr i_sqrt_nr (
    .clk(clk), .rst_n(rst_n), .start(start), .value(value),
    .busy(busy), .done(done), .root_fx(root_fx),
    .int_bcd(int_bcd), .frac_bcd(frac_bcd)
  );

  function automatic longint model_root(input int s);
    longint x, q;
    if (s == 0) return 0;
    x = (s < 32) ? 5 * 1024 : (s < 81) ? 9 * 1024 : 16 * 1024;
    for (int k = 0; k < 4; k++) begin
      q = (longint'(s) << 20) / x;
      x = (x + q) / 2;
    end
    return x;
  endfunction

  function automatic logic [11:0] dec3(input longint v);
    return {4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // run one computation; if intr is set, a second start with value 7 is pulsed while busy
  task automatic run(input int v, input bit intr);
    int n;
    longint er;
    string tag;
    @(negedge clk);
    start = 1'b1;
    value = 8'(v);
    @(negedge clk);
    start = 1'b0;
    value = 8'd0;
    if (v != 0) check("R5 busy", busy, 1);
    n = 0;
    forever begin
      if (intr && n == 40) begin
        start = 1'b1;
        value = 8'd7;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
      if (done) break;
      if (v != 0 && !busy) begin
        check("R5 busy held", 0, 1);
        break;
      end
      if (n > 400) begin
        check("R5 timeout", n, 117);
        break;
      end
    end
    start = 1'b0;
    check(v == 0 ? "R4 latency" : "R5 latency", n, (v == 0) ? 1 : 117);
    check("R6 busy at done", busy, 0);
    er = model_root(v);
    tag = (v == 31 || v == 32 || v == 80 || v == 81) ? "R2" : (v == 0 ? "R4" : (intr ? "R7" : "R3"));
    check(tag, root_fx, er);
    check("R8", int_bcd, dec3(er >> 10));
    check("R9", frac_bcd, dec3(((er & 1023) * 1000) >> 10));
    @(negedge clk);
    check("R6 pulse", done, 0);
    repeat (3) @(negedge clk);
    check("R7 hold", root_fx, er);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 root", root_fx, 0);
    check("R1 bcd", {int_bcd, frac_bcd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 256; v++) run(v, 1'b0);
    run(200, 1'b1);
    run(0, 1'b0);
    run(255, 1'b1);
    finish_run();
  end
endmodule